// File: doc/BRIEF.md
# Bit-Field Extract, Insert and Funnel Shift Unit

This block performs the 32-bit bit-field operations an integer datapath needs. Each operation takes two source words, a bit position and a field width (both 0..31). Five operations are offered: signed field extract, unsigned field extract, mask-pair generation, field insert into a word, and a funnel extract across two words. The funnel extract acts as a rotate when both sources carry the same value. All operations are combinational. An optional output register, selected by a parameter, cuts the path.

Three operations are only legal when position plus width is at most 31: signed extract, mask generation and insert. When the limit is broken, the write flag `out_wr` is low and both result words read zero, which tells the consumer to leave its destination untouched. Unsigned extract and funnel extract write for every position/width pair. The operation codes are 0 signed extract, 1 unsigned extract, 2 mask generation, 3 insert and 4 funnel extract. The codes 5 to 7 are unused.

Requests arrive on a valid/ready stream and results leave on another. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. With the output register present, a result stays on the outputs, unchanged, until a clock edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. Without the register, both handshakes pass straight through.

Top module: `bfx_unit`

## Requirements
- R1: Signed extract (op 0) with pos+width <= 31 returns (A << (32-pos-width)) shifted right arithmetically by (32-width), and sets out_wr. With width 0 it returns 0.
- R2: Unsigned extract (op 1) returns 0 when width is 0. Otherwise it returns (A >> pos) keeping only the low width bits. It sets out_wr for every pos/width pair.
- R3: Mask generation (op 2) with pos+width <= 31 puts ((1<<width)-1)<<pos on out_sec and B<<pos on out_pri, and sets out_wr.
- R4: Insert (op 3) with pos+width <= 31 returns A with bits pos..pos+width-1 replaced by the low width bits of B. All other bits of A are kept, and width 0 returns A unchanged.
- R5: Funnel extract (op 4) returns (B << pos) | (A >> (32-pos)), and returns B unchanged when pos is 0. When A equals B the result is B rotated left by pos. It sets out_wr for every pos/width pair.
- R6: For ops 0, 2 and 3 with pos+width > 31, out_wr is low and out_pri and out_sec are zero.
- R7: Unused op codes 5..7 give out_wr low and both result words zero.
- R8: out_sec is zero for every op other than mask generation.
- R9: With the output register present, a pending result (out_valid high, out_ready low) keeps out_valid high and holds its values until drained. in_ready equals (!out_valid || out_ready), and an accepted request shows on the outputs one cycle after the edge that takes it.
- R10: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| op | input | 3 | Operation code (0..4 used) |
| src_a | input | 32 | Source word A |
| src_b | input | 32 | Source word B |
| pos | input | 5 | Bit position |
| width | input | 5 | Field width |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pri | output | 32 | Primary result |
| out_sec | output | 32 | Secondary result (mask of mask generation) |
| out_wr | output | 1 | Result is to be written |

## Verification
The hardest cases to reach are the boundaries of the legality limit: pos+width exactly 31 against 32, and the far corners such as pos 31 with width 31. These sit in a thin slice of the input space that random operands alone seldom land on. The stimulus therefore sweeps every position/width pair exhaustively for each operation, with fresh random sources on each pair. The equal-source rotate is also hard to hit by chance, so directed requests drive identical sources. A held-output episode with a queued second request covers back-pressure.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_SEXT = 3'd0,
    OP_UEXT = 3'd1,
    OP_MASK = 3'd2,
    OP_INS  = 3'd3,
    OP_FUN  = 3'd4
  } bfx_op_e;
endpackage

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DW = 32,
  localparam int PW = $clog2(DW)
) (
  input  logic [DW-1:0] src,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] width,
  output logic [DW-1:0] sext,
  output logic [DW-1:0] uext
);
  logic [DW-1:0] low_m;
  logic [DW-1:0] field;
  logic [PW-1:0] top_idx;
  logic          sgn;

  always_comb begin
    low_m   = ~({DW{1'b1}} << width);
    field   = (src >> pos) & low_m;
    top_idx = width - PW'(1);
    sgn     = (width != '0) ? field[top_idx] : 1'b0;
    uext    = field;
    sext    = sgn ? (field | ~low_m) : field;
  end
endmodule

// File: rtl/bfx_mask_insert.sv
module bfx_mask_insert #(
  parameter int DW = 32,
  localparam int PW = $clog2(DW)
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] width,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] b_shl,
  output logic [DW-1:0] ins
);
  logic [DW-1:0] low_m;

  always_comb begin
    low_m = ~({DW{1'b1}} << width);
    mask  = low_m << pos;
    b_shl = b << pos;
    ins   = (a & ~mask) | (b_shl & mask);
  end
endmodule

// File: rtl/bfx_funnel.sv
module bfx_funnel #(
  parameter int DW = 32,
  localparam int PW = $clog2(DW)
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [PW-1:0] pos,
  output logic [DW-1:0] res
);
  logic [2*DW-1:0] pair;

  always_comb begin
    pair = {b, a} << pos;
    res  = pair[2*DW-1:DW];
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int PW     = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  input  logic [PW-1:0]   pos,
  input  logic [PW-1:0]   width,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_pri,
  output logic [DW-1:0]   out_sec,
  output logic            out_wr
);
  logic [DW-1:0] x_sext, x_uext, m_mask, m_bshl, m_ins, f_res;
  logic [DW-1:0] c_pri, c_sec;
  logic          c_wr, fits, fire;
  logic [PW:0]   span;

  bfx_extract #(.DW(DW)) u_ext (
    .src(src_a), .pos(pos), .width(width), .sext(x_sext), .uext(x_uext));

  bfx_mask_insert #(.DW(DW)) u_mi (
    .a(src_a), .b(src_b), .pos(pos), .width(width),
    .mask(m_mask), .b_shl(m_bshl), .ins(m_ins));

  bfx_funnel #(.DW(DW)) u_fun (
    .a(src_a), .b(src_b), .pos(pos), .res(f_res));

  always_comb begin
    span  = {1'b0, pos} + {1'b0, width};
    fits  = span <= (PW+1)'(DW-1);
    c_pri = '0;
    c_sec = '0;
    c_wr  = 1'b0;
    case (bfx_op_e'(op))
      OP_SEXT: if (fits) begin c_pri = x_sext; c_wr = 1'b1; end
      OP_UEXT: begin c_pri = x_uext; c_wr = 1'b1; end
      OP_MASK: if (fits) begin c_pri = m_bshl; c_sec = m_mask; c_wr = 1'b1; end
      OP_INS:  if (fits) begin c_pri = m_ins; c_wr = 1'b1; end
      OP_FUN:  begin c_pri = f_res; c_wr = 1'b1; end
      default: ;
    endcase
  end

  assign fire = in_valid && in_ready;

  generate
    if (REG_OUT) begin : g_reg
      logic          v_q, w_q;
      logic [DW-1:0] p_q, s_q;
      assign in_ready = !v_q || out_ready;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          w_q <= 1'b0;
          p_q <= '0;
          s_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) begin
            w_q <= c_wr;
            p_q <= c_pri;
            s_q <= c_sec;
          end
        end
      end
      assign out_valid = v_q;
      assign out_wr    = w_q;
      assign out_pri   = p_q;
      assign out_sec   = s_q;

      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pri) && $stable(out_sec) && $stable(out_wr));
      assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_wr    = c_wr;
      assign out_pri   = c_pri;
      assign out_sec   = c_sec;
    end
  endgenerate

  assert_mask_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_MASK && fits |-> $countones(c_sec) == int'(width));
  assert_uext_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_UEXT |-> $countones(c_pri) <= int'(width));
  assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_FUN && src_a == src_b |-> $countones(c_pri) == $countones(src_a));
  assert_sec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op != OP_MASK |-> c_sec == '0);
  assert_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !fits && (op == OP_SEXT || op == OP_MASK || op == OP_INS) |-> !c_wr && c_pri == '0);
endmodule

// File: tb/tb_bfx_unit.sv
`timescale 1ns/1ps
module tb_bfx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  pos = '0, width = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pri, out_sec;
  logic        out_wr;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bfx_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src_a(src_a), .src_b(src_b), .pos(pos), .width(width),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pri(out_pri), .out_sec(out_sec), .out_wr(out_wr));

  function automatic bit legal(input int p, input int w);
    return (p + w) <= 31;
  endfunction

  function automatic logic [31:0] lowm(input int w);
    return 32'(((64'd1) << w) - 64'd1);
  endfunction

  // Expected {wr, pri, sec} from the requirements
  function automatic logic [64:0] model(input int o, input logic [31:0] a,
                                        input logic [31:0] b, input int p, input int w);
    logic [31:0] pr, se, m;
    int t;
    bit wr;
    pr = 0; se = 0; wr = 0;
    case (o)
      0: if (legal(p, w)) begin
           wr = 1;
           if (w != 0) begin t = int'(a << (32 - p - w)); pr = 32'(t >>> (32 - w)); end
         end
      1: begin wr = 1; pr = (w == 0) ? 32'd0 : ((a >> p) & lowm(w)); end
      2: if (legal(p, w)) begin wr = 1; se = lowm(w) << p; pr = b << p; end
      3: if (legal(p, w)) begin
           wr = 1; pr = a;
           for (int i = 0; i < w; i++) pr[p+i] = b[i];
         end
      4: begin wr = 1; pr = (p == 0) ? b : ((b << p) | (a >> (32 - p))); end
      default: ;
    endcase
    m = se;
    return {wr, pr, m};
  endfunction

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got wr=%0b pri=%h sec=%h expected wr=%0b pri=%h sec=%h",
               req, got[64], got[63:32], got[31:0], exp[64], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic run(input string req, input int o, input logic [31:0] a,
                     input logic [31:0] b, input int p, input int w);
    @(negedge clk);
    op = 3'(o); src_a = a; src_b = b; pos = 5'(p); width = 5'(w); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {64'd0, out_valid}, {64'd0, 1'b1});
    check(req, {out_wr, out_pri, out_sec}, model(o, a, b, p, w));
  endtask

  initial begin : watchdog
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tag [5] = '{"R1", "R2", "R3", "R4", "R5"};
    void'($urandom(32'h5eed_0042));
    #12;
    check("R10 reset", {63'd0, out_valid, in_ready}, {63'd0, 1'b0, 1'b1});
    rst_n = 1'b1;

    // exhaustive pos/width sweep per operation, random sources (R1..R6, R8)
    for (int o = 0; o < 5; o++)
      for (int p = 0; p < 32; p++)
        for (int w = 0; w < 32; w++)
          run(legal(p, w) ? tag[o] : {tag[o], "/R6"}, o, $urandom, $urandom, p, w);

    // directed corners
    run("R4 width0 keeps A", 3, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 7, 0);
    run("R5 pos0 returns B", 4, 32'h1234_5678, 32'hCAFE_F00D, 0, 9);
    run("R5 rotate", 4, 32'h8000_0001, 32'h8000_0001, 1, 0);
    run("R5 rotate", 4, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 13, 3);
    run("R1 boundary", 0, 32'h4000_0000, 32'h0, 30, 1);
    run("R6 over limit", 0, 32'hFFFF_FFFF, 32'h0, 31, 1);
    run("R3 full span", 2, 32'h0, 32'h1, 0, 31);
    for (int o = 5; o < 8; o++) run("R7 unused op", o, $urandom, $urandom, 3, 4);
    for (int i = 0; i < 200; i++) begin
      int o = int'($urandom_range(0, 4));
      run(tag[o], o, $urandom, $urandom, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
    end

    // back-pressure (R9)
    @(negedge clk);
    out_ready = 1'b0;
    op = 3'd2; src_a = 32'h0; src_b = 32'h0000_0003; pos = 5'd4; width = 5'd2; in_valid = 1'b1;
    @(negedge clk);
    check("R9 in_ready low while full", {64'd0, in_ready}, {64'd0, 1'b0});
    op = 3'd4; src_a = 32'hF000_0000; src_b = 32'h0000_0001; pos = 5'd4; width = 5'd0;
    @(negedge clk);
    @(negedge clk);
    check("R9 held valid", {64'd0, out_valid}, {64'd0, 1'b1});
    check("R9 held data", {out_wr, out_pri, out_sec}, {1'b1, 32'h30, 32'h30});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 queued request", {out_wr, out_pri, out_sec}, {1'b1, 32'h0000_001F, 32'h0});
    @(negedge clk);
    check("R9 drained", {64'd0, out_valid}, {64'd0, 1'b0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule